// File: doc/BRIEF.md
# CAN Acceptance Screener

This block decides whether a received CAN frame should go into the receive buffer. It sits after the bit-level receiver. That receiver hands it an already parsed frame: the format flag, the remote flag, the identifier, the data length and the first two data bytes, all qualified by a one-cycle valid strobe. Four screeners each hold a 32-bit compare value and a 32-bit mask. A per-screener mode chooses how that 64-bit pair is laid over the frame:

- a single extended-identifier screener;
- a standard-identifier screener that also checks two data bytes;
- a pair of standard-identifier screeners, the first of which also checks one data byte.

Software can rewrite the screeners while traffic continues. Writes land in a shadow copy. The shadow copy becomes live at the clock edge that ends each frame's evaluation. Because of this, a single frame is always judged against one consistent set of values. The verdict is registered and stays on the outputs until the next frame. It consists of a hit flag and the index of the lowest-numbered matching screener half.

Top module: `can_screen_top`

## Requirements
- R1: After reset, hit is 0 and hit_idx is 0. Every shadow and live compare value, mask, mode and enable bit is 0, so all screeners are disabled.
- R2: Write addresses are as follows (NSCR = 4 screeners). Address s (0..NSCR-1) is the compare value of screener s. Address NSCR+s is the mask of screener s. Address 2*NSCR is the control word. In the control word, bits [2s+1:2s] are the mode of screener s and bit 2*NSCR+s is its enable. Writes update only the shadow copy.
- R3: A mask bit of 1 makes the corresponding compare bit don't-care. A mask bit of 0 requires the frame bit to equal the compare bit.
- R4: The mode codes are 0 = extended, 1 = standard with two data bytes, 2 = dual standard, 3 = never matches. Mode 0 matches only frames with IDE=1. Modes 1 and 2 match only frames with IDE=0. A disabled screener never matches.
- R5: In extended mode, word bits [31:3] hold the 29-bit identifier and bit 2 holds RTR. Bits [1:0] are ignored.
- R6: In standard-with-data mode, the word bits are laid out as follows. Bits [31:21] hold the 11-bit identifier and bit 20 holds RTR. Bits [19:16] are ignored. Bits [15:8] hold data byte 0 and bits [7:0] hold data byte 1.
- R7: In dual mode, half 0 uses bits [31:21] for the identifier, bit 20 for RTR and bits [19:12] for data byte 0. Half 1 uses bits [11:1] for the identifier and bit 0 for RTR, and it never checks data. Only standard frames can hit either half.
- R8: A data-byte comparison is don't-care when the frame is remote (RTR=1) or when its data length does not reach that byte: length 0 for byte 0, length below 2 for byte 1.
- R9: The frame is accepted when any enabled screener half matches. hit_idx = 2*s + half, where half is 0 for single-screener modes, and the lowest matching index wins. On a miss, hit_idx is 0.
- R10: hit and hit_idx change only at the clock edge where frame_vld is high, which is one clock after the strobe is presented. They hold their values until the next strobe.
- R11: At each edge where frame_vld is high, the frame is evaluated with the live values, and the shadow contents are then copied into the live set. A write therefore first affects the frame after the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Screener register write enable |
| cfg_addr | input | 4 | Screener register address |
| cfg_wdata | input | 32 | Write data |
| frame_vld | input | 1 | One-cycle strobe: parsed frame fields valid |
| frame_ide | input | 1 | 1 = extended identifier frame |
| frame_rtr | input | 1 | 1 = remote frame |
| frame_id | input | 29 | Identifier; standard frames use bits [10:0] |
| frame_dlc | input | 4 | Data length code |
| frame_d0 | input | 8 | First data byte |
| frame_d1 | input | 8 | Second data byte |
| hit | output | 1 | Frame accepted |
| hit_idx | output | 3 | Index of winning screener half |

## Verification
Every wrong bit in the live compare, mask, mode or enable state shows up as a wrong verdict. It appears on the first frame that exercises that bit, one clock after its strobe, and it persists until the next strobe. A shadow copy that goes live too early or too late shows up as a verdict that is off by exactly one frame after a write. The stimulus brackets each write with a frame that must still see the old setting and a frame that must see the new one. Priority faults show up only when two halves match the same frame, so overlapping screeners are enabled together on purpose.

// File: rtl/can_screen_pkg.sv
package can_screen_pkg;

    typedef enum logic [1:0] {
        SM_EXT  = 2'd0,
        SM_STD2 = 2'd1,
        SM_DUAL = 2'd2,
        SM_OFF  = 2'd3
    } scr_mode_e;

    typedef struct packed {
        logic        ide;
        logic        rtr;
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [7:0]  d0;
        logic [7:0]  d1;
    } frame_t;

endpackage

// File: rtl/screen_match.sv
module screen_match
    import can_screen_pkg::*;
(
    input  scr_mode_e   mode,
    input  logic        en,
    input  logic [31:0] mval,
    input  logic [31:0] mmask,
    input  frame_t      fr,
    output logic        hit_a,
    output logic        hit_b
);
    function automatic logic fits(input logic [31:0] f, input logic [31:0] m,
                                  input logic [31:0] k);
        return &((f ~^ m) | k);
    endfunction

    logic        skip_d0;
    logic        skip_d1;
    logic [31:0] word;
    logic [31:0] xdc;

    always_comb begin
        skip_d0 = fr.rtr || (fr.dlc == 4'd0);
        skip_d1 = fr.rtr || (fr.dlc < 4'd2);
        word    = '0;
        xdc     = '0;
        hit_a   = 1'b0;
        hit_b   = 1'b0;
        case (mode)
            SM_EXT: begin
                word  = {fr.id, fr.rtr, 2'b00};
                xdc   = 32'h0000_0003;
                hit_a = en && fr.ide && fits(word, mval, mmask | xdc);
            end
            SM_STD2: begin
                word  = {fr.id[10:0], fr.rtr, 4'h0, fr.d0, fr.d1};
                xdc   = {12'h000, 4'hF, {8{skip_d0}}, {8{skip_d1}}};
                hit_a = en && !fr.ide && fits(word, mval, mmask | xdc);
            end
            SM_DUAL: begin
                word  = {fr.id[10:0], fr.rtr, fr.d0, fr.id[10:0], fr.rtr};
                xdc   = {12'h000, {8{skip_d0}}, 12'h000};
                hit_a = en && !fr.ide && fits(word, mval, mmask | xdc | 32'h0000_0FFF);
                hit_b = en && !fr.ide && fits(word, mval, mmask | 32'hFFFF_F000);
            end
            default: begin
                hit_a = 1'b0;
                hit_b = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/screen_pick.sv
module screen_pick #(
    parameter int NHALF = 8,
    parameter int IDXW  = 3
) (
    input  logic [NHALF-1:0] hits,
    output logic             any,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = NHALF - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/can_screen_top.sv
module can_screen_top
    import can_screen_pkg::*;
#(
    parameter int NSCR = 4,
    parameter int AW   = 4,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [31:0]     cfg_wdata,
    input  logic            frame_vld,
    input  logic            frame_ide,
    input  logic            frame_rtr,
    input  logic [28:0]     frame_id,
    input  logic [3:0]      frame_dlc,
    input  logic [7:0]      frame_d0,
    input  logic [7:0]      frame_d1,
    output logic            hit,
    output logic [IDXW-1:0] hit_idx
);
    localparam int NHALF    = 2 * NSCR;
    localparam int CTRL_ADR = 2 * NSCR;
    localparam int EN_BASE  = 2 * NSCR;
    localparam int ACTW     = NSCR * (2 * 32 + 3);

    typedef struct packed {
        logic [NSCR-1:0][31:0] sh_val;
        logic [NSCR-1:0][31:0] sh_msk;
        logic [NSCR-1:0][1:0]  sh_mode;
        logic [NSCR-1:0]       sh_en;
        logic [NSCR-1:0][31:0] ac_val;
        logic [NSCR-1:0][31:0] ac_msk;
        logic [NSCR-1:0][1:0]  ac_mode;
        logic [NSCR-1:0]       ac_en;
        logic                  hit;
        logic [IDXW-1:0]       idx;
    } st_t;

    st_t              st_d, st_q;
    frame_t           fr;
    logic [NHALF-1:0] hits;
    logic             any_hit;
    logic [IDXW-1:0]  win_idx;
    logic [ACTW-1:0]  act_flat;
    logic [NSCR-1:0]  en_act;

    assign fr = '{ide: frame_ide, rtr: frame_rtr, id: frame_id, dlc: frame_dlc,
                  d0: frame_d0, d1: frame_d1};

    for (genvar s = 0; s < NSCR; s++) begin : g_scr
        screen_match u_match (
            .mode  (scr_mode_e'(st_q.ac_mode[s])),
            .en    (st_q.ac_en[s]),
            .mval  (st_q.ac_val[s]),
            .mmask (st_q.ac_msk[s]),
            .fr    (fr),
            .hit_a (hits[2*s]),
            .hit_b (hits[2*s+1])
        );
    end

    screen_pick #(.NHALF(NHALF), .IDXW(IDXW)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int s = 0; s < NSCR; s++) begin
                if (cfg_addr == AW'(s))        st_d.sh_val[s] = cfg_wdata;
                if (cfg_addr == AW'(NSCR + s)) st_d.sh_msk[s] = cfg_wdata;
                if (cfg_addr == AW'(CTRL_ADR)) begin
                    st_d.sh_mode[s] = cfg_wdata[2*s +: 2];
                    st_d.sh_en[s]   = cfg_wdata[EN_BASE + s];
                end
            end
        end
        if (frame_vld) begin
            st_d.hit     = any_hit;
            st_d.idx     = any_hit ? win_idx : '0;
            st_d.ac_val  = st_q.sh_val;
            st_d.ac_msk  = st_q.sh_msk;
            st_d.ac_mode = st_q.sh_mode;
            st_d.ac_en   = st_q.sh_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit      = st_q.hit;
    assign hit_idx  = st_q.idx;
    assign en_act   = st_q.ac_en;
    assign act_flat = {st_q.ac_val, st_q.ac_msk, st_q.ac_mode, st_q.ac_en};
endmodule

module can_screen_chk #(
    parameter int NSCR = 4,
    parameter int IDXW = 3,
    parameter int ACTW = 268
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_vld,
    input logic            frame_ide,
    input logic            hit,
    input logic [IDXW-1:0] hit_idx,
    input logic [NSCR-1:0] en_act,
    input logic [ACTW-1:0] act_flat
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(hit) && $stable(hit_idx)));

    assert_none_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && (en_act == '0)) |=> !hit);

    assert_half1_std_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame_ide) |=> !(hit && hit_idx[0]));

    assert_live_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(act_flat));
endmodule

bind can_screen_top can_screen_chk #(.NSCR(NSCR), .IDXW(IDXW), .ACTW(ACTW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld),
    .frame_ide (frame_ide),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .en_act    (en_act),
    .act_flat  (act_flat)
);

// File: tb/sim_can_screen_top.sv
module sim_can_screen_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_vld = 1'b0;
    logic        frame_ide = 1'b0;
    logic        frame_rtr = 1'b0;
    logic [28:0] frame_id = '0;
    logic [3:0]  frame_dlc = '0;
    logic [7:0]  frame_d0 = '0;
    logic [7:0]  frame_d1 = '0;
    logic        hit;
    logic [2:0]  hit_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    can_screen_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_vld(frame_vld), .frame_ide(frame_ide),
        .frame_rtr(frame_rtr), .frame_id(frame_id), .frame_dlc(frame_dlc),
        .frame_d0(frame_d0), .frame_d1(frame_d1), .hit(hit), .hit_idx(hit_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [3:0] act,
                         input logic [3:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got hit/idx=%0d/%0d expected %0d/%0d",
                     tag, act[3], act[2:0], exp[3], exp[2:0]);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input bit ide, input bit rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [7:0] d0,
                        input logic [7:0] d1, input bit eh, input logic [2:0] ei,
                        input string tag);
        exp_q.push_back({eh, ei});
        tag_q.push_back(tag);
        @(negedge clk);
        frame_vld = 1'b1; frame_ide = ide; frame_rtr = rtr; frame_id = id;
        frame_dlc = dlc; frame_d0 = d0; frame_d1 = d1;
        @(negedge clk);
        frame_vld = 1'b0;
        @(negedge clk);
    endtask

    // monitor: verdict appears at the edge that sampled the strobe
    initial begin
        forever begin
            @(posedge clk);
            if (frame_vld) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [3:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({hit, hit_idx} == e, t, {hit, hit_idx}, e);
                end
            end
        end
    end

    initial begin
        #3_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({hit, hit_idx} == 4'h0, "R1 reset outputs", {hit, hit_idx}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({hit, hit_idx} == 4'h0, "R1 after release", {hit, hit_idx}, 4'h0);

        // R2 map: s0 ext, s1 std+data, s2 dual, s3 std catch-all
        wr(4'd0, {29'h1234567, 1'b0, 2'b00});
        wr(4'd4, 32'h0);
        wr(4'd1, {11'h123, 1'b0, 4'h0, 8'hAA, 8'h55});
        wr(4'd5, 32'h0010_0000);
        wr(4'd2, {11'h200, 1'b0, 8'h11, 11'h300, 1'b0});
        wr(4'd6, 32'h0000_001E);
        wr(4'd3, 32'h0);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0000_0764);

        send(1, 0, 29'h1234567, 4'd8, 8'h0, 8'h0, 0, 3'd0, "R11 shadow not yet live");
        send(1, 0, 29'h1234567, 4'd8, 8'h0, 8'h0, 1, 3'd0, "R5 ext exact");
        send(1, 0, 29'h1234566, 4'd8, 8'h0, 8'h0, 0, 3'd0, "R3 ext id bit differs");
        send(0, 0, 29'h123, 4'd2, 8'hAA, 8'h55, 1, 3'd2, "R6 std id+data");
        send(0, 0, 29'h123, 4'd2, 8'hAA, 8'h56, 0, 3'd0, "R6 data byte1 differs");
        send(0, 0, 29'h123, 4'd1, 8'hAA, 8'h56, 1, 3'd2, "R8 short dlc skips byte1");
        send(0, 1, 29'h123, 4'd8, 8'h00, 8'h00, 1, 3'd2, "R8 remote skips data");
        send(0, 0, 29'h200, 4'd1, 8'h11, 8'h0, 1, 3'd4, "R7 dual half0");
        send(0, 0, 29'h200, 4'd1, 8'h12, 8'h0, 0, 3'd0, "R7 dual half0 byte0 differs");
        send(0, 0, 29'h200, 4'd0, 8'h99, 8'h0, 1, 3'd4, "R8 dlc0 skips byte0");
        send(0, 0, 29'h30A, 4'd0, 8'h0, 8'h0, 1, 3'd5, "R3 dual half1 masked id");

        repeat (5) @(negedge clk);
        check({hit, hit_idx} == 4'hD, "R10 verdict held", {hit, hit_idx}, 4'hD);

        send(0, 0, 29'h310, 4'd0, 8'h0, 8'h0, 0, 3'd0, "R7 dual half1 miss");
        send(1, 0, 29'h0000123, 4'd2, 8'hAA, 8'h55, 0, 3'd0, "R4 ext frame vs std screeners");

        wr(4'd8, 32'h0000_0F64);
        send(0, 0, 29'h3FF, 4'd0, 8'h0, 8'h0, 0, 3'd0, "R11 enable pending");
        send(0, 0, 29'h3FF, 4'd0, 8'h0, 8'h0, 1, 3'd6, "R9 catch-all now live");
        send(0, 0, 29'h123, 4'd2, 8'hAA, 8'h55, 1, 3'd2, "R9 lowest index wins");

        wr(4'd8, 32'h0000_0064);
        send(0, 0, 29'h3FF, 4'd0, 8'h0, 8'h0, 1, 3'd6, "R11 disable pending");
        send(0, 0, 29'h123, 4'd2, 8'hAA, 8'h55, 0, 3'd0, "R4 all disabled miss");

        wr(4'd8, 32'h0000_0103);
        send(0, 0, 29'h3FF, 4'd0, 8'h0, 8'h0, 0, 3'd0, "R2 commit ctrl");
        send(1, 0, 29'h1234567, 4'd8, 8'h0, 8'h0, 0, 3'd0, "R4 mode 3 never matches");

        wr(4'd8, 32'h0000_0100);
        send(0, 0, 29'h3FF, 4'd0, 8'h0, 8'h0, 0, 3'd0, "R2 commit ext again");
        send(1, 1, 29'h1234567, 4'd0, 8'h0, 8'h0, 0, 3'd0, "R5 rtr bit compared");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R10: got %0d pending verdicts expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule